// File: doc/BRIEF.md
# Descriptor Channel Interrupt and Reset Controller

This block is the control slice of one descriptor-processing channel in a crypto offload engine. The channel datapath reports two kinds of per-descriptor outcome: a successful completion, or an error with a code. This block turns those outcomes into a DONE interrupt request and an ERROR interrupt request for the central controller.

Completion events are qualified by a done-interrupt enable and by a notification mode. In global mode every good descriptor counts. In per-descriptor mode a descriptor counts only if the done-notify flag in its header is set. Qualified events are held in a saturating pending counter, so events that arrive before the host acknowledges earlier ones are not lost. The host acknowledges one event at a time with a write-one-to-clear pulse.

The block also sequences software reset. What the channel does depends on where it stands in execution-unit arbitration. While it is still requesting a unit, it withdraws the request with a release strobe and resets itself. Once it has been granted a unit, it first asks the controller to write that unit's reset bit, and only after that write is acknowledged does it reset itself.

Top module: `chan_irq_rst_ctrl`

## Requirements
- R1: While `cfg_done_ie` is 0, no descriptor completion changes `done_pending`.
- R2: With `cfg_notify_global` = 1 and `cfg_done_ie` = 1, every `desc_done` pulse in the active state adds one to `done_pending`. A `desc_done` pulse that comes with `desc_err` in the same cycle is never counted.
- R3: With `cfg_notify_global` = 0, a `desc_done` pulse counts only when `desc_notify` is 1.
- R4: `done_pending` goes up by one in the cycle after each qualified event, and `irq_done` is 1 exactly while `done_pending` is nonzero.
- R5: Each `done_ack` pulse lowers `done_pending` by one. An acknowledge when the count is zero leaves it at zero.
- R6: A qualified event and a `done_ack` in the same cycle leave `done_pending` unchanged.
- R7: `done_pending` saturates at 2^CNT_W-1, which is 7 by default. Further events leave it there.
- R8: `irq_err` rises in the same cycle that `desc_err` is seen in the active state. It then stays high until the self reset.
- R9: `err_code` (4 bits) records the code of the first error and keeps it until reset. Later errors, and completions arriving after the error, change neither `err_code` nor `done_pending`.
- R10: If the reset bit is set while `eu_req` is high, `eu_req` drops and `eu_release` is high for exactly one cycle. No reset write is requested, and the channel self-resets to idle.
- R11: If the reset bit is set after a grant, including in the error halt, `eu_rst_wr_req` stays high until `eu_rst_wr_ack`. Until that acknowledge, no register is cleared.
- R12: The self reset clears `done_pending`, `err_code`, `irq_err`, `irq_done` and `reset_busy`, and returns the channel to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| cfg_done_ie | input | 1 | Done interrupt enable |
| cfg_notify_global | input | 1 | 1: every good descriptor notifies; 0: only those with the header flag |
| cfg_reset_wr | input | 1 | Host write pulse that sets the channel reset bit |
| start | input | 1 | Descriptor ready; channel starts requesting a unit |
| eu_grant | input | 1 | Execution unit granted |
| desc_done | input | 1 | Descriptor completed pulse |
| desc_notify | input | 1 | Done-notify flag from the descriptor header |
| desc_err | input | 1 | Descriptor error pulse |
| desc_err_code | input | 4 | Error type that comes with `desc_err` |
| done_ack | input | 1 | Write-one-to-clear acknowledge of one done event |
| eu_rst_wr_ack | input | 1 | Controller has done the unit reset write |
| irq_done | output | 1 | DONE interrupt request |
| irq_err | output | 1 | ERROR interrupt request |
| eu_req | output | 1 | Execution unit request |
| eu_release | output | 1 | Withdraw the unit request |
| eu_rst_wr_req | output | 1 | Request a write of the unit's reset bit |
| reset_busy | output | 1 | Reset bit, as read back |
| err_code | output | 4 | Status: first error code |
| done_pending | output | 3 | Status: queued done events |

## Verification
A completion event and a host acknowledge can land on the same clock edge. The bench drives `desc_done` and `done_ack` together with a nonzero count and expects the count unchanged. It repeats this with the count saturated, where the event must not push it past the ceiling. A reset request and an arbitration step can also coincide. The reset bit is set while the request is still outstanding and also after the grant, and the bench checks which of the release strobe or the reset-write request appears and when the status is cleared.

// File: rtl/chanirq_pkg.sv
package chanirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ_EU   = 3'd1,
    ST_ACTIVE   = 3'd2,
    ST_EU_RSTWR = 3'd3,
    ST_SELF_RST = 3'd4,
    ST_ERR_HALT = 3'd5
  } chan_state_e;

  // A completion is reported when enabled and either global mode or header flag.
  function automatic logic done_qualifies(input logic ie, input logic glob,
                                          input logic hdr_flag);
    return ie & (glob | hdr_flag);
  endfunction

endpackage

// File: rtl/chan_done_queue.sv
module chan_done_queue #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             evt,
  input  logic             ack,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic e, input logic a);
    logic [CNT_W-1:0] r;
    r = c;
    if (e && !a) begin
      if (c != CNT_MAX) r = c + 1'b1;
    end else if (a && !e) begin
      if (c != '0) r = c - 1'b1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else            count <= next_count(count, evt, ack);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && evt && !clear) |=> (count == CNT_MAX)); // R7
  AST_BALANCED_EVT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ack && !clear) |=> $stable(count)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && ack && !evt) |=> (count == '0)); // R5

endmodule

// File: rtl/chan_err_capture.sv
module chan_err_capture #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              err_evt,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              latched
);
  logic first_err;
  assign first_err = err_evt && !latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      latched <= 1'b0;
    end else if (clear) begin
      code_q  <= '0;
      latched <= 1'b0;
    end else if (first_err) begin
      code_q  <= code_in;
      latched <= 1'b1;
    end
  end

  AST_FIRST_ERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clear) |=> $stable(code_q)); // R9

endmodule

// File: rtl/chan_rst_fsm.sv
module chan_rst_fsm
  import chanirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        eu_grant,
  input  logic        reset_bit,
  input  logic        desc_err,
  input  logic        eu_rst_wr_ack,
  output chan_state_e state,
  output logic        eu_req,
  output logic        eu_release,
  output logic        eu_rst_wr_req,
  output logic        self_rst,
  output logic        active
);
  chan_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (reset_bit) nxt = ST_SELF_RST;
                   else if (start) nxt = ST_REQ_EU;
      ST_REQ_EU:   if (reset_bit) nxt = ST_SELF_RST;
                   else if (eu_grant) nxt = ST_ACTIVE;
      ST_ACTIVE:   if (reset_bit) nxt = ST_EU_RSTWR;
                   else if (desc_err) nxt = ST_ERR_HALT;
      ST_ERR_HALT: if (reset_bit) nxt = ST_EU_RSTWR;
      ST_EU_RSTWR: if (eu_rst_wr_ack) nxt = ST_SELF_RST;
      ST_SELF_RST: nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign eu_req        = (state == ST_REQ_EU) && !reset_bit;
  assign eu_release    = (state == ST_REQ_EU) && reset_bit;
  assign eu_rst_wr_req = (state == ST_EU_RSTWR);
  assign self_rst      = (state == ST_SELF_RST);
  assign active        = (state == ST_ACTIVE) && !reset_bit;

  AST_RELEASE_THEN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    eu_release |=> (self_rst && !eu_release)); // R10
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eu_rst_wr_req && !eu_rst_wr_ack) |=> eu_rst_wr_req); // R11
  AST_WR_THEN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (eu_rst_wr_req && eu_rst_wr_ack) |=> self_rst); // R11
  AST_SELF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    self_rst |=> (state == ST_IDLE)); // R12

endmodule

// File: rtl/chan_irq_rst_ctrl.sv
module chan_irq_rst_ctrl
  import chanirq_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done_ie,
  input  logic              cfg_notify_global,
  input  logic              cfg_reset_wr,
  input  logic              start,
  input  logic              eu_grant,
  input  logic              desc_done,
  input  logic              desc_notify,
  input  logic              desc_err,
  input  logic [CODE_W-1:0] desc_err_code,
  input  logic              done_ack,
  input  logic              eu_rst_wr_ack,
  output logic              irq_done,
  output logic              irq_err,
  output logic              eu_req,
  output logic              eu_release,
  output logic              eu_rst_wr_req,
  output logic              reset_busy,
  output logic [CODE_W-1:0] err_code,
  output logic [CNT_W-1:0]  done_pending
);
  chan_state_e state;
  logic        self_rst;
  logic        active;
  logic        done_evt;
  logic        err_evt;
  logic        err_latched;

  // Software reset bit: set by host, cleared by the self reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            reset_busy <= 1'b0;
    else if (self_rst)     reset_busy <= 1'b0;
    else if (cfg_reset_wr) reset_busy <= 1'b1;
  end

  chan_rst_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .eu_grant      (eu_grant),
    .reset_bit     (reset_busy),
    .desc_err      (desc_err),
    .eu_rst_wr_ack (eu_rst_wr_ack),
    .state         (state),
    .eu_req        (eu_req),
    .eu_release    (eu_release),
    .eu_rst_wr_req (eu_rst_wr_req),
    .self_rst      (self_rst),
    .active        (active)
  );

  assign err_evt  = active && desc_err;
  assign done_evt = active && desc_done && !desc_err &&
                    done_qualifies(cfg_done_ie, cfg_notify_global, desc_notify);

  chan_done_queue #(.CNT_W(CNT_W)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (self_rst),
    .evt   (done_evt),
    .ack   (done_ack),
    .count (done_pending)
  );

  chan_err_capture #(.CODE_W(CODE_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (self_rst),
    .err_evt (err_evt),
    .code_in (desc_err_code),
    .code_q  (err_code),
    .latched (err_latched)
  );

  assign irq_done = (done_pending != '0);
  assign irq_err  = err_evt || err_latched;

  AST_ERR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && !reset_busy && desc_err) |-> irq_err); // R8
  AST_ERR_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERR_HALT) |-> irq_err); // R8
  AST_DONE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done_ie && !done_ack && !self_rst) |=> (done_pending >= $past(done_pending))
      && (done_pending <= $past(done_pending))); // R1
  AST_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    self_rst |=> (done_pending == '0 && err_code == '0 && !reset_busy)); // R12

endmodule

// File: tb/chan_irq_rst_ctrl_tb.sv
module chan_irq_rst_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_done_ie, cfg_notify_global, cfg_reset_wr;
  logic       start, eu_grant, desc_done, desc_notify, desc_err;
  logic [3:0] desc_err_code;
  logic       done_ack, eu_rst_wr_ack;
  logic       irq_done, irq_err, eu_req, eu_release, eu_rst_wr_req, reset_busy;
  logic [3:0] err_code;
  logic [2:0] done_pending;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  chan_irq_rst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_done_ie(cfg_done_ie),
    .cfg_notify_global(cfg_notify_global), .cfg_reset_wr(cfg_reset_wr),
    .start(start), .eu_grant(eu_grant), .desc_done(desc_done),
    .desc_notify(desc_notify), .desc_err(desc_err), .desc_err_code(desc_err_code),
    .done_ack(done_ack), .eu_rst_wr_ack(eu_rst_wr_ack), .irq_done(irq_done),
    .irq_err(irq_err), .eu_req(eu_req), .eu_release(eu_release),
    .eu_rst_wr_req(eu_rst_wr_req), .reset_busy(reset_busy),
    .err_code(err_code), .done_pending(done_pending)
  );

  // {done_ie, global, header_flag, expected increment}
  localparam logic [3:0] VEC [0:7] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110,
    4'b1000, 4'b1011, 4'b1101, 4'b1111
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic go_active();
    start = 1'b1; cyc(); start = 1'b0;
    eu_grant = 1'b1; cyc(); eu_grant = 1'b0;
  endtask

  task automatic pulse_done(input logic ie, input logic gl, input logic nf,
                            input logic ak);
    cfg_done_ie = ie; cfg_notify_global = gl; desc_notify = nf;
    desc_done = 1'b1; done_ack = ak; cyc();
    desc_done = 1'b0; done_ack = 1'b0; desc_notify = 1'b0;
  endtask

  task automatic ack_once();
    done_ack = 1'b1; cyc(); done_ack = 1'b0;
  endtask

  task automatic full_reset_from_granted();
    cfg_reset_wr = 1'b1; cyc(); cfg_reset_wr = 1'b0;
    cyc();
    eu_rst_wr_ack = 1'b1; cyc(); eu_rst_wr_ack = 1'b0;
    cyc();
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_done_ie = 0; cfg_notify_global = 0; cfg_reset_wr = 0;
    start = 0; eu_grant = 0; desc_done = 0; desc_notify = 0; desc_err = 0;
    desc_err_code = 0; done_ack = 0; eu_rst_wr_ack = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();

    // Reset state
    chk("R12 reset pending", done_pending, 0);
    chk("R12 reset irq_done", irq_done, 0);
    chk("R12 reset irq_err", irq_err, 0);
    chk("R12 reset eu_req", eu_req, 0);
    chk("R12 reset err_code", err_code, 0);

    go_active();

    // Table walk: R1, R2, R3
    for (int i = 0; i < 8; i++) begin
      pulse_done(VEC[i][3], VEC[i][2], VEC[i][1], 1'b0);
      if (!VEC[i][3]) chk("R1 disabled done", done_pending, 0);
      else if (VEC[i][2]) chk("R2 global done", done_pending, int'(VEC[i][0]));
      else chk("R3 per-descriptor done", done_pending, int'(VEC[i][0]));
      chk("R4 irq_done follows count", irq_done, int'(VEC[i][0]));
      if (VEC[i][0]) ack_once();
    end

    // Queueing R4, R5, R6
    pulse_done(1, 1, 0, 0);
    pulse_done(1, 1, 0, 0);
    pulse_done(1, 0, 1, 0);
    chk("R4 three queued", done_pending, 3);
    ack_once();
    chk("R5 ack decrements", done_pending, 2);
    pulse_done(1, 1, 0, 1);
    chk("R6 event with ack", done_pending, 2);
    ack_once(); ack_once();
    chk("R5 drained", done_pending, 0);
    chk("R4 irq_done low at zero", irq_done, 0);
    ack_once();
    chk("R5 ack at zero", done_pending, 0);

    // Saturation R7
    for (int k = 0; k < 9; k++) pulse_done(1, 1, 0, 0);
    chk("R7 saturated", done_pending, 7);
    pulse_done(1, 1, 0, 1);
    chk("R7 R6 event with ack at ceiling", done_pending, 7);
    for (int k = 0; k < 7; k++) ack_once();
    chk("R5 drained after saturation", done_pending, 0);

    // Done together with error is not counted R2, error same cycle R8
    cfg_done_ie = 1; cfg_notify_global = 1;
    desc_done = 1; desc_err = 1; desc_err_code = 4'd5;
    #1;
    chk("R8 irq_err same cycle", irq_err, 1);
    cyc();
    desc_done = 0; desc_err = 0; desc_err_code = 0;
    chk("R2 errored descriptor not counted", done_pending, 0);
    chk("R9 first code", err_code, 5);
    chk("R8 irq_err held", irq_err, 1);
    desc_err = 1; desc_err_code = 4'd9; cyc(); desc_err = 0; desc_err_code = 0;
    chk("R9 later error ignored", err_code, 5);
    pulse_done(1, 1, 0, 0);
    chk("R9 done after error ignored", done_pending, 0);

    // Reset from error halt R11, R12
    cfg_reset_wr = 1; cyc(); cfg_reset_wr = 0;
    cyc();
    chk("R11 reset write requested", eu_rst_wr_req, 1);
    chk("R11 no release after grant", eu_release, 0);
    cyc(); cyc(); cyc();
    chk("R11 write held", eu_rst_wr_req, 1);
    chk("R11 code kept before write", err_code, 5);
    chk("R11 reset bit kept", reset_busy, 1);
    eu_rst_wr_ack = 1; cyc(); eu_rst_wr_ack = 0;
    chk("R11 write dropped", eu_rst_wr_req, 0);
    cyc();
    chk("R12 code cleared", err_code, 0);
    chk("R12 irq_err cleared", irq_err, 0);
    chk("R12 reset bit cleared", reset_busy, 0);

    // Reset from active with pending count R11, R12
    go_active();
    pulse_done(1, 1, 0, 0); pulse_done(1, 1, 0, 0);
    chk("R4 pending before reset", done_pending, 2);
    full_reset_from_granted();
    chk("R12 pending cleared", done_pending, 0);
    chk("R12 irq_done cleared", irq_done, 0);

    // Reset while requesting R10
    start = 1; cyc(); start = 0;
    chk("R10 requesting", eu_req, 1);
    cfg_reset_wr = 1; cyc(); cfg_reset_wr = 0;
    chk("R10 release high", eu_release, 1);
    chk("R10 request dropped", eu_req, 0);
    chk("R10 no reset write", eu_rst_wr_req, 0);
    cyc();
    chk("R10 release one cycle", eu_release, 0);
    cyc();
    chk("R10 reset bit cleared", reset_busy, 0);
    chk("R10 idle no request", eu_req, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule